// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device end of a serial flash that answers read commands. A host drives chip select (active low), a serial clock and a serial data input in SPI mode 0. The block returns bytes on a serial output that has a data bit and an output enable, so that a pad can tri-state it. The serial pins are sampled with the system clock `clk`, which must run at least eight times faster than the serial clock.

Two opcodes start a continuous read that streams data with no gap. It crosses page boundaries and wraps from the end of the array back to the start. A third opcode starts a single-page read. That read needs 32 dummy bits after the address and loops inside one page. A static input selects how the address splits into page and byte, using either 528-byte or 512-byte pages. The storage array is loaded through a write port. The byte at page `p`, offset `b` sits at index `p*528 + b` in both modes.

Top module: `sflash_rd`

## Requirements
- R1: Opcodes 0x03 and 0x01 start a continuous read. After the 24 address bits, the next falling serial clock edge drives the first data bit. No dummy bits are used.
- R2: Opcode 0xD2 starts a single-page read. The 24 address bits are followed by 32 dummy bits. `so_oe` stays 0 until the falling edge after the last dummy bit.
- R3: When `page512`=0, address bits 21:10 give the page and bits 9:0 give the byte offset. Bits 23:22 are ignored.
- R4: When `page512`=1, address bits 20:9 give the page and bits 8:0 give the byte offset. The page holds 512 bytes.
- R5: In a continuous read, the byte after the last byte of a page is byte 0 of the next page, with no extra clocks.
- R6: In a continuous read, the byte after the last byte of the last page is byte 0 of page 0, with no extra clocks.
- R7: Raising `cs_n` ends any operation. `so_oe` goes to 0 within six `clk` cycles, and the next selection decodes a fresh opcode.
- R8: Reads do not alter the array. Reading the same address again returns the same bytes.
- R9: `si` is sampled on rising serial clock edges and `so` changes only after falling edges. Bytes go most significant bit first.
- R10: A single-page read that passes the last byte of its page continues at byte 0 of the same page.
- R11: Any other opcode keeps `so_oe` at 0 until `cs_n` goes high.
- R12: When `page512`=0, a byte offset above 527 is reduced by 528.
- R13: The page number is taken modulo the array's page count, 2**PAGE_BITS.
- R14: After reset, `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| page512 | input | 1 | Page mode: 1 selects 512-byte pages, 0 selects 528-byte pages (static) |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| ld_we | input | 1 | Array load strobe |
| ld_addr | input | $clog2(528*2**PAGE_BITS) | Array load index, page*528+byte |
| ld_data | input | 8 | Array load byte |

## Verification
The assertions check four things on every cycle:
- the output enable drops while deselected and stays low after an unknown opcode;
- the output enable rises, and the data bit moves, only after a detected falling serial clock edge;
- the byte offset always stays inside the active page size;
- a single-page read never changes its page.

Other behaviour can only be shown by the directed scenarios, because it depends on what value reaches the host:
- the address split in each mode, the modulo reduction of the offset and of the page number;
- the page and array crossovers;
- the length of the dummy phase;
- the data returned after an abort and after repeated reads.

// File: rtl/sflash_rd.sv
module sflash_rd #(
  parameter int PAGE_BITS = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   page512,
  input  logic                                   cs_n,
  input  logic                                   sck,
  input  logic                                   si,
  output logic                                   so,
  output logic                                   so_oe,
  input  logic                                   ld_we,
  input  logic [$clog2(528*(2**PAGE_BITS))-1:0]  ld_addr,
  input  logic [7:0]                             ld_data
);
  localparam int PSTD  = 528;
  localparam int PAGES = 2 ** PAGE_BITS;
  localparam int DEPTH = PAGES * PSTD;
  localparam int AW    = $clog2(DEPTH);

  typedef enum logic [2:0] {S_CMD, S_ADR, S_DMY, S_DAT, S_IGN} st_t;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (ld_we) mem[ld_addr] <= ld_data;

  logic sck_m, sck_s, sck_d, si_m, si_s, cs_m, cs_s;
  logic rise, fall;
  st_t  st;
  logic [5:0] cnt;
  logic [20:0] sh;
  logic [21:0] sh_n;
  logic single;
  logic [PAGE_BITS-1:0] pg;
  logic [9:0] by;
  logic [2:0] bi;
  logic so_q, oe_q;
  logic in_data, in_ign;

  assign rise    = sck_s & ~sck_d;
  assign fall    = ~sck_s & sck_d;
  assign sh_n    = {sh, si_s};
  assign in_data = (st == S_DAT);
  assign in_ign  = (st == S_IGN);
  assign so      = so_q;
  assign so_oe   = oe_q;

  logic [11:0] dec_pg12;
  logic [9:0]  raw10, dec_by, last_by;
  assign dec_pg12 = page512 ? sh_n[20:9] : sh_n[21:10];
  assign raw10    = sh_n[9:0];
  assign dec_by   = page512 ? {1'b0, sh_n[8:0]}
                            : ((raw10 >= 10'd528) ? raw10 - 10'd528 : raw10);
  assign last_by  = page512 ? 10'd511 : 10'd527;

  logic [AW-1:0] rd_idx;
  logic [7:0]    rd_byte;
  assign rd_idx  = AW'(pg) * AW'(PSTD) + AW'(by);
  assign rd_byte = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= 1'b0; sck_s <= 1'b0; sck_d <= 1'b0;
      si_m  <= 1'b0; si_s  <= 1'b0;
      cs_m  <= 1'b1; cs_s  <= 1'b1;
      st    <= S_CMD;
      cnt   <= '0;
      sh    <= '0;
      single <= 1'b0;
      pg    <= '0;
      by    <= '0;
      bi    <= '0;
      so_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sck_m <= sck;  sck_s <= sck_m; sck_d <= sck_s;
      si_m  <= si;   si_s  <= si_m;
      cs_m  <= cs_n; cs_s  <= cs_m;
      if (cs_s) begin
        st   <= S_CMD;
        cnt  <= '0;
        oe_q <= 1'b0;
      end else begin
        if (rise) begin
          case (st)
            S_CMD: begin
              sh <= sh_n[20:0];
              if (cnt == 6'd7) begin
                cnt <= '0;
                case (sh_n[7:0])
                  8'h03, 8'h01: begin st <= S_ADR; single <= 1'b0; end
                  8'hD2:        begin st <= S_ADR; single <= 1'b1; end
                  default:      st <= S_IGN;
                endcase
              end else cnt <= cnt + 6'd1;
            end
            S_ADR: begin
              sh <= sh_n[20:0];
              if (cnt == 6'd23) begin
                cnt <= '0;
                pg  <= PAGE_BITS'(dec_pg12 % 12'(PAGES));
                by  <= dec_by;
                bi  <= '0;
                st  <= single ? S_DMY : S_DAT;
              end else cnt <= cnt + 6'd1;
            end
            S_DMY: begin
              if (cnt == 6'd31) begin
                cnt <= '0;
                st  <= S_DAT;
              end else cnt <= cnt + 6'd1;
            end
            default: ;
          endcase
        end
        if (fall && st == S_DAT) begin
          so_q <= rd_byte[~bi];
          oe_q <= 1'b1;
          bi   <= bi + 3'd1;
          if (bi == 3'd7) begin
            if (by == last_by) begin
              by <= '0;
              if (!single) pg <= pg + PAGE_BITS'(1);
            end else begin
              by <= by + 10'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sflash_rd_chk.sv
module sflash_rd_chk #(
  parameter int PAGE_BITS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_s,
  input logic                 fall,
  input logic                 so,
  input logic                 so_oe,
  input logic                 page512,
  input logic [9:0]           by,
  input logic [PAGE_BITS-1:0] pg,
  input logic                 single,
  input logic                 in_data,
  input logic                 in_ign
);
  // R7
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_oe);

  // R9
  so_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(so));

  // R9
  oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(fall));

  // R11
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ign |-> !so_oe);

  // R3
  std_offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !page512) |-> (by < 10'd528));

  // R4
  bin_offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && page512) |-> (by < 10'd512));

  // R10
  page_read_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && single && $past(in_data)) |-> (pg == $past(pg)));
endmodule

bind sflash_rd sflash_rd_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall(fall), .so(so), .so_oe(so_oe),
  .page512(page512), .by(by), .pg(pg), .single(single),
  .in_data(in_data), .in_ign(in_ign)
);

// File: tb/sim_sflash_rd.sv
`timescale 1ns/1ps
module sim_sflash_rd;
  localparam int PB    = 2;
  localparam int PAGES = 2 ** PB;
  localparam int DEPTH = PAGES * 528;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic page512 = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic so_pin;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;
  assign so_pin = so_oe ? so : 1'bz;

  sflash_rd #(.PAGE_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .page512(page512), .cs_n(cs_n), .sck(sck),
    .si(si), .so(so), .so_oe(so_oe), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 13) ^ (i >> 5) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] exp_byte(int p, int b);
    return pat(p * 528 + b);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output bit oe_any);
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) si = tx[i];
      repeat (7) @(negedge clk);
      rx[i] = so_pin;
      if (so_oe) oe_any = 1'b1;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk) cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_read(input logic [7:0] op, input logic [23:0] adr, input int nb,
                          input bit dummy, input int sp, input int sb, input bit cont,
                          input string req);
    logic [7:0] rx;
    bit oe;
    int p = sp, b = sb;
    int last = page512 ? 511 : 527;
    sel();
    spi_byte(op, rx, oe);
    chk(!oe, req, "oe during opcode", 8'(oe), 8'h0);
    for (int k = 2; k >= 0; k--) begin
      spi_byte(adr[k*8 +: 8], rx, oe);
      chk(!oe, req, "oe during address", 8'(oe), 8'h0);
    end
    if (dummy)
      for (int k = 0; k < 4; k++) begin
        spi_byte(8'h00, rx, oe);
        chk(!oe, "R2", "oe during dummy", 8'(oe), 8'h0);
      end
    for (int k = 0; k < nb; k++) begin
      spi_byte(8'h00, rx, oe);
      chk(rx === exp_byte(p, b), req, $sformatf("data p%0d b%0d", p, b), rx, exp_byte(p, b));
      if (b == last) begin
        b = 0;
        if (cont) p = (p + 1) % PAGES;
      end else b++;
    end
    desel();
    chk(!so_oe, "R7", "oe after deselect", 8'(so_oe), 8'h0);
  endtask

  task automatic t_reset();
    chk(!so_oe, "R14", "oe after reset", 8'(so_oe), 8'h0);
  endtask

  task automatic t_cont_std();
    page512 = 1'b0;
    run_read(8'h03, 24'h000405, 3, 1'b0, 1, 5, 1'b1, "R1 R3 R9");
  endtask

  task automatic t_cont_bin();
    page512 = 1'b1;
    run_read(8'h01, 24'h00052C, 3, 1'b0, 2, 300, 1'b1, "R1 R4");
    page512 = 1'b0;
  endtask

  task automatic t_page_cross();
    run_read(8'h03, 24'h00020E, 4, 1'b0, 0, 526, 1'b1, "R5");
  endtask

  task automatic t_array_wrap();
    page512 = 1'b1;
    run_read(8'h03, 24'h0007FE, 4, 1'b0, 3, 510, 1'b1, "R6");
    page512 = 1'b0;
  endtask

  task automatic t_page_read();
    run_read(8'hD2, 24'h000A0E, 4, 1'b1, 2, 526, 1'b0, "R2 R10");
  endtask

  task automatic t_offset_mod();
    run_read(8'h03, 24'h0007E8, 2, 1'b0, 1, 472, 1'b1, "R12");
  endtask

  task automatic t_page_alias();
    run_read(8'h01, 24'hC01403, 2, 1'b0, 1, 3, 1'b1, "R13 R3");
  endtask

  task automatic t_repeat();
    run_read(8'h03, 24'h000C10, 2, 1'b0, 3, 16, 1'b1, "R8");
    run_read(8'h03, 24'h000C10, 2, 1'b0, 3, 16, 1'b1, "R8");
  endtask

  task automatic t_unknown();
    logic [7:0] rx;
    bit oe;
    sel();
    spi_byte(8'h9F, rx, oe);
    for (int k = 0; k < 4; k++) begin
      spi_byte(8'h00, rx, oe);
      chk(!oe, "R11", "oe after unknown opcode", 8'(oe), 8'h0);
    end
    desel();
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    bit oe;
    sel();
    spi_byte(8'h03, rx, oe);
    spi_byte(8'h00, rx, oe);
    spi_byte(8'h04, rx, oe);
    spi_byte(8'h00, rx, oe);
    spi_byte(8'h00, rx, oe);
    chk(rx === exp_byte(1, 0), "R7", "byte before abort", rx, exp_byte(1, 0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
      repeat (8) @(negedge clk);
    end
    chk(so_oe, "R7", "oe mid-byte", 8'(so_oe), 8'h1);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!so_oe, "R7", "oe after abort", 8'(so_oe), 8'h0);
    repeat (4) @(negedge clk);
    run_read(8'h03, 24'h000002, 2, 1'b0, 0, 2, 1'b1, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      ld_we = 1'b1; ld_addr = AW'(i); ld_data = pat(i);
      @(negedge clk);
    end
    ld_we = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cont_std();
    t_cont_bin();
    t_page_cross();
    t_array_wrap();
    t_page_read();
    t_offset_mod();
    t_page_alias();
    t_repeat();
    t_unknown();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule